// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller

This block sequences a successive-approximation analog-to-digital converter that sits behind a small register file on a 32-bit APB-style bus. To start a conversion, software writes a channel number into the control word and sets its power bit in the same write. The controller then holds off for a programmable number of converter-clock periods so that the analog front end can settle. After that it runs a bit-serial search: on each clock it drives a trial code to the DAC and reads back one comparator bit.

When the search ends, the controller stores the code as a right-aligned result, drops the busy flag and sets an interrupt status bit. The interrupt line follows that bit when interrupts are enabled. A control write with the power bit clear stops any conversion in progress, powers the converter down and clears the pending interrupt. The analog comparator and DAC are outside the block, and a single clock drives everything.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset all four registers read zero, the interrupt line is low, the power output is low and the DAC code is zero.
- R2: The registers sit at these byte offsets: result at 0x00 (read-only), status at 0x04, control at 0x08 and settle delay at 0x0C. In the control word, bits [2:0] select the channel, bit 3 is power, bit 5 is interrupt enable and bit 6 is interrupt status. Only the low 6 bits of the delay register are stored; the other bits read zero. The channel output follows control bits [2:0].
- R3: A control write with bit 3 set, accepted while idle, makes status bit 0 (busy) high. The conversion completes D+1+N clock edges after the write edge, where D is the delay value and N is the result width.
- R4: The search resolves bits from MSB to LSB. A trial bit is kept only when the comparator input is high, meaning the input is at or above the DAC level. For an input code v, the result is therefore v, right-aligned, with all upper bits zero.
- R5: In the first search cycle the DAC code is exactly the MSB. Each later cycle adds the next lower trial bit to the bits already kept. The DAC code is zero whenever no search is running.
- R6: On completion, control bit 6 is set. The interrupt output equals control bit 6 AND control bit 5.
- R7: Reading the result register does not clear the interrupt status.
- R8: A control write with bit 3 clear makes the block idle and powered down on the next edge. It aborts any conversion without changing the result, and it clears interrupt status when bit 6 of the written data is 0. Writing 1 to bit 6 leaves the status unchanged.
- R9: A control write with bit 3 set while busy is ignored. The control fields stay as they were, and the running conversion finishes on its original channel.
- R10: The result is taken from the channel selected when the conversion started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | 4 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request |
| adcPowerOn | output | 1 | Converter power enable |
| adcChan | output | 3 | Analog channel select |
| dacCode | output | 10 | Trial code to the DAC |
| cmpIn | input | 1 | Comparator: input at or above DAC level |

## Verification
The bench sweeps every 10-bit input code across all channels in turn. A search that kept bits on the wrong comparator sense, or that stopped one bit early, would return codes that differ from the input. The settle delay is measured at 0, 1, 8 and 63, which exposes an off-by-one in the countdown or a delay register that stores too many bits. The bench also issues a start write while busy and an abort write in the middle of the settle phase. A design that accepted the second start would report the wrong channel. One that let an aborted search finish would raise the interrupt or overwrite the previous result.

// File: rtl/sarc_pkg.sv
package sarc_pkg;
  typedef struct packed {
    logic loadDly;
    logic decDly;
    logic init;
    logic step;
    logic latch;
    logic drive;
  } sarStrobe_t;

  localparam logic [1:0] REG_RESULT = 2'd0;
  localparam logic [1:0] REG_STATUS = 2'd1;
  localparam logic [1:0] REG_CTRL   = 2'd2;
  localparam logic [1:0] REG_DELAY  = 2'd3;
endpackage

// File: rtl/sarc_datapath.sv
module sarc_datapath
  import sarc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int DLY_BITS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  sarStrobe_t          st,
  input  logic [DLY_BITS-1:0] dlyVal,
  input  logic                cmpIn,
  output logic                dlyZero,
  output logic                lastBit,
  output logic [RES_BITS-1:0] dacCode,
  output logic [RES_BITS-1:0] result
);
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code;
  logic [RES_BITS-1:0] trialBit;
  logic [RES_BITS-1:0] codeNext;
  logic [DLY_BITS-1:0] dlyCnt;

  assign codeNext = cmpIn ? (code | trialBit) : code;
  assign dlyZero  = (dlyCnt == '0);
  assign lastBit  = trialBit[0];
  assign dacCode  = st.drive ? (code | trialBit) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlyCnt <= '0;
    end else if (st.loadDly) begin
      dlyCnt <= dlyVal;
    end else if (st.decDly) begin
      dlyCnt <= dlyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code     <= '0;
      trialBit <= '0;
    end else if (st.init) begin
      code     <= '0;
      trialBit <= MSB_ONE;
    end else if (st.step) begin
      code     <= codeNext;
      trialBit <= trialBit >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
    end else if (st.latch) begin
      result <= codeNext;
    end
  end

  // R5: at most one trial bit is ever live
  a_r5_trial_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trialBit));

  // R4/R8: the result only moves on a latch strobe
  a_r4_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !st.latch |=> $stable(result));
endmodule

// File: rtl/sarc_control.sv
module sarc_control
  import sarc_pkg::*;
#(
  parameter int RES_BITS  = 10,
  parameter int DLY_BITS  = 6,
  parameter int CHAN_BITS = 3,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  input  logic                 dlyZero,
  input  logic                 lastBit,
  input  logic [RES_BITS-1:0]  result,
  output sarStrobe_t           st,
  output logic [DLY_BITS-1:0]  dlyReg,
  output logic                 irq,
  output logic                 pwrReg,
  output logic [CHAN_BITS-1:0] chanReg
);
  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_CONV} state_t;

  state_t state, nextState;
  logic   ienReg, istReg;
  logic   wrEn, wrCtrl, abortNow, startNow, busy, doneNow;
  logic   unusedBits;

  assign wrEn     = psel && penable && pwrite;
  assign wrCtrl   = wrEn && (paddr[3:2] == REG_CTRL);
  assign abortNow = wrCtrl && !pwdata[3];
  assign startNow = wrCtrl && pwdata[3] && (state == S_IDLE);
  assign busy     = (state != S_IDLE);
  assign doneNow  = (state == S_CONV) && lastBit && !abortNow;
  assign irq      = istReg && ienReg;
  assign unusedBits = ^{pwdata[DATA_W-1:7], pwdata[4], paddr[1:0]};

  always_comb begin
    st        = '0;
    nextState = state;
    if (abortNow) begin
      nextState = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (startNow) begin
          st.loadDly = 1'b1;
          nextState  = S_SETTLE;
        end
        S_SETTLE: if (dlyZero) begin
          st.init   = 1'b1;
          nextState = S_CONV;
        end else begin
          st.decDly = 1'b1;
        end
        S_CONV: begin
          st.drive = 1'b1;
          st.step  = 1'b1;
          if (lastBit) begin
            st.latch  = 1'b1;
            nextState = S_IDLE;
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
    if (abortNow && state == S_CONV) st.drive = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      chanReg <= '0;
      pwrReg  <= 1'b0;
      ienReg  <= 1'b0;
      istReg  <= 1'b0;
      dlyReg  <= '0;
    end else begin
      state <= nextState;
      if (wrEn && paddr[3:2] == REG_DELAY) dlyReg <= pwdata[DLY_BITS-1:0];
      if (abortNow || startNow) begin
        chanReg <= pwdata[CHAN_BITS-1:0];
        ienReg  <= pwdata[5];
        istReg  <= istReg && pwdata[6];
        pwrReg  <= startNow;
      end else if (doneNow) begin
        istReg <= 1'b1;
      end
    end
  end

  always_comb begin
    prdata = '0;
    unique case (paddr[3:2])
      REG_RESULT: prdata[RES_BITS-1:0] = result;
      REG_STATUS: prdata[0] = busy;
      REG_CTRL: begin
        prdata[CHAN_BITS-1:0] = chanReg;
        prdata[3] = pwrReg;
        prdata[5] = ienReg;
        prdata[6] = istReg;
      end
      default: prdata[DLY_BITS-1:0] = dlyReg;
    endcase
  end

  // R9: a running conversion keeps its channel unless aborted
  a_r9_chan_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abortNow) |=> $stable(chanReg));

  // R6: finishing the last bit sets status and leaves busy
  a_r6_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CONV && lastBit && !wrCtrl) |=> (istReg && state == S_IDLE));

  // R8: a write with power clear idles and powers down
  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abortNow |=> (state == S_IDLE && !pwrReg));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sarc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int NUM_CHAN = 8,
  parameter int DLY_BITS = 6,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  localparam int CHAN_BITS = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [DATA_W-1:0]    pwdata,
  output logic [DATA_W-1:0]    prdata,
  output logic                 irq,
  output logic                 adcPowerOn,
  output logic [CHAN_BITS-1:0] adcChan,
  output logic [RES_BITS-1:0]  dacCode,
  input  logic                 cmpIn
);
  sarStrobe_t          st;
  logic                dlyZero, lastBit;
  logic [DLY_BITS-1:0] dlyReg;
  logic [RES_BITS-1:0] result;

  sarc_control #(
    .RES_BITS(RES_BITS), .DLY_BITS(DLY_BITS), .CHAN_BITS(CHAN_BITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .dlyZero(dlyZero), .lastBit(lastBit), .result(result), .st(st),
    .dlyReg(dlyReg), .irq(irq), .pwrReg(adcPowerOn), .chanReg(adcChan)
  );

  sarc_datapath #(.RES_BITS(RES_BITS), .DLY_BITS(DLY_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .dlyVal(dlyReg), .cmpIn(cmpIn),
    .dlyZero(dlyZero), .lastBit(lastBit), .dacCode(dacCode), .result(result)
  );
endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb;
  localparam int RES = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq, adcPowerOn, cmpIn;
  logic [2:0]  adcChan;
  logic [RES-1:0] dacCode;
  logic [RES-1:0] vinCh [8];

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  assign cmpIn = (vinCh[adcChan] >= dacCode);

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
    .adcPowerOn(adcPowerOn), .adcChan(adcChan), .dacCode(dacCode), .cmpIn(cmpIn)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  // counts negedge polls after a start write until irq is seen
  task automatic waitIrq(output int polls);
    polls = 1;
    while (!irq && polls < 400) begin
      @(negedge clk);
      polls++;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int polls;
    for (int i = 0; i < 8; i++) vinCh[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 4; r++) begin
      busRead(4'(r * 4), rd);
      check(rd == 0, "R1 register reset", rd, 0);
    end
    check(irq == 0 && adcPowerOn == 0 && dacCode == 0, "R1 outputs reset",
          {irq, adcPowerOn, dacCode}, 0);

    // R2 field layout and delay width
    busWrite(4'hC, 32'hFFFF_FFFF);
    busRead(4'hC, rd);
    check(rd == 32'h3F, "R2 delay width", rd, 32'h3F);
    busWrite(4'h8, 32'h27);
    busRead(4'h8, rd);
    check(rd == 32'h27, "R2 control fields", rd, 32'h27);
    check(adcChan == 3'd7, "R2 channel output", adcChan, 7);

    // R3 settle timing
    foreach (vinCh[i]) vinCh[i] = 10'd123;
    for (int k = 0; k < 4; k++) begin
      int d;
      d = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 8 : 63;
      busWrite(4'hC, 32'(d));
      busWrite(4'h8, 32'h28);
      busRead(4'h4, rd);
      check(rd == 1, "R3 busy after start", rd, 1);
      busWrite(4'h8, 32'h2C);
      busWrite(4'hC, 32'(d));
      busWrite(4'h8, 32'h00);
      busWrite(4'h8, 32'h28);
      waitIrq(polls);
      check(polls == d + 2 + RES, "R3 conversion length", polls, d + 2 + RES);
      busRead(4'h4, rd);
      check(rd == 0, "R3 busy after completion", rd, 0);
    end

    // R5 DAC sequence and idle value
    vinCh[0] = 10'd600;
    busWrite(4'hC, 32'h0);
    busWrite(4'h8, 32'h28);
    @(negedge clk);
    check(dacCode == 10'h200, "R5 first trial is MSB", dacCode, 10'h200);
    @(negedge clk);
    check(dacCode == 10'h300, "R5 second trial", dacCode, 10'h300);
    waitIrq(polls);
    check(dacCode == 0, "R5 idle DAC code", dacCode, 0);

    // R4 and R10 full sweep across channels
    busWrite(4'hC, 32'h0);
    for (int v = 0; v < (1 << RES); v++) begin
      int ch;
      ch = v % 8;
      vinCh[ch] = 10'(v);
      vinCh[(ch + 1) % 8] = 10'(~v);
      busWrite(4'h8, 32'(32'h28 | ch));
      waitIrq(polls);
      busRead(4'h0, rd);
      check(rd == 32'(v), "R4 R10 search result", rd, v);
    end

    // R7 reading the result keeps status
    busRead(4'h0, rd);
    busRead(4'h0, rd);
    busRead(4'h8, rd);
    check(rd[6] == 1'b1 && irq == 1'b1, "R7 status kept after data read", {rd[6], irq}, 3);

    // R6 interrupt gating
    vinCh[0] = 10'd77;
    busWrite(4'h8, 32'h08);
    rd = 32'h1;
    for (int t = 0; t < 40 && rd[0]; t++) busRead(4'h4, rd);
    check(irq == 0, "R6 irq masked", irq, 0);
    busRead(4'h8, rd);
    check(rd == 32'h48, "R6 status set on completion", rd, 32'h48);
    busWrite(4'h8, 32'h60);
    check(irq == 1, "R6 irq when enabled", irq, 1);
    busWrite(4'h8, 32'h20);
    check(irq == 0, "R8 status cleared by zero bit", irq, 0);
    busRead(4'h0, rd);
    check(rd == 77, "R4 masked conversion result", rd, 77);

    // R9 start while busy is ignored
    vinCh[1] = 10'd300; vinCh[5] = 10'd700;
    busWrite(4'hC, 32'd20);
    busWrite(4'h8, 32'h29);
    busWrite(4'h8, 32'h2D);
    busRead(4'h8, rd);
    check(rd == 32'h29, "R9 control unchanged", rd, 32'h29);
    check(adcChan == 3'd1, "R9 channel kept", adcChan, 1);
    waitIrq(polls);
    busRead(4'h0, rd);
    check(rd == 300, "R9 original channel result", rd, 300);

    // R8 abort in mid-settle
    vinCh[2] = 10'd55;
    busWrite(4'hC, 32'd40);
    busWrite(4'h8, 32'h2A);
    repeat (3) @(negedge clk);
    busWrite(4'h8, 32'h0);
    check(adcPowerOn == 0 && dacCode == 0, "R8 powered down", {adcPowerOn, dacCode}, 0);
    busRead(4'h4, rd);
    check(rd == 0, "R8 busy cleared", rd, 0);
    repeat (120) @(negedge clk);
    check(irq == 0, "R8 no interrupt after abort", irq, 0);
    busRead(4'h0, rd);
    check(rd == 300, "R8 result unchanged", rd, 300);
    busRead(4'h8, rd);
    check(rd == 0, "R8 control cleared", rd, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule